// File: doc/BRIEF.md
# UART Indexed Control Extension with RS485 Driver Enable

This block extends a byte-wide, 16550-style UART register file with a gated, indexed control register set. Software unlocks a configuration view by loading a key value into the line control register. In that view a feature register holds an enable bit for extended control. While that bit is set and the normal view is active, the scratch slot becomes an index pointer and the line-status slot becomes a data window onto the indexed registers. Index 0 reaches an additional control register.

Two bits of the additional control register choose how the DTR output pin is driven. The pin can follow the modem control register as usual, or it can act as an active-low transmit enable for an external RS485 line driver. In that second mode the pin is pulled low for as long as the transmitter holds data, including the stop bits of the last character. The transmit queue and the shift register are outside this block and appear only as two status inputs. Line status also comes in from outside.

Each register occupies a 32-bit word, so the register slot is the byte address shifted right by two. Reads have no side effects, and the read data is combinational from the current address.

Top module: `uart_idx_ext`

## Requirements
- R1: After reset the line control, modem control, scratch, feature, index and additional control registers all read 0x00, and `dtr_pin_o` is high.
- R2: The register slot is `bus_addr >> 2`, and address bits [1:0] are ignored. Slots 0, 1, 6 and any slot not named in these requirements read 0x00 and ignore writes. Slot 3 is the line control register in every view, and slot 4 is the modem control register in the normal view.
- R3: While the line control register holds 0xBF (configuration view), slot 2 reads and writes the feature register, and slots 4, 5 and 7 read 0x00 and ignore writes. In any other view, slot 2 reads 0x00 and a write there leaves the feature register unchanged.
- R4: With feature bit 4 (extended-control enable) clear, slot 7 is a plain read/write scratch register. Slot 5 reads `line_status_i`, and writes to slot 5 are ignored.
- R5: With feature bit 4 set in the normal view, slot 7 reads and writes the index register. The scratch value is kept and becomes readable again once bit 4 is cleared.
- R6: With extended control enabled and index 0, slot 5 reads and writes all 8 bits of the additional control register, so a read-modify-write leaves bits outside [4:3] exactly as they were.
- R7: With extended control enabled and a nonzero index, slot 5 reads 0x00 and writes change no register.
- R8: When additional control bits [4:3] are not 10 (00 is the compatible setting, and 01 and 11 behave the same way), `dtr_pin_o` equals the inverse of modem control bit 0, one clock after that bit changes. The transmitter inputs have no effect in this mode.
- R9: When additional control bits [4:3] are 10, `dtr_pin_o` is low one clock after `txq_empty_i` is 0 or `tx_shift_busy_i` is 1, and high one clock after both show idle. Modem control bit 0 has no effect in this mode.
- R10: `bus_rdata` is 0x00 whenever `bus_rd` is low, and a read changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (5) | Byte address; bits [ADDR_W-1:2] select the slot |
| bus_wr | input | 1 | Write strobe, taken at the rising edge |
| bus_rd | input | 1 | Read enable for combinational read data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0x00 when not reading |
| line_status_i | input | 8 | Line status from the serial core |
| txq_empty_i | input | 1 | Transmit queue is empty |
| tx_shift_busy_i | input | 1 | Shift register is sending, stop bits included |
| dtr_pin_o | output | 1 | Registered DTR pin level |

## Verification
The assertions check on every cycle that at most one slot decode is active. They also check that the feature, scratch and additional control registers change only under their own gated write strobe, that a write through a nonzero index leaves the additional control register alone, and that reads disturb nothing. The DTR pin is checked against the previous cycle's mode, modem control bit and transmitter activity in both modes. Only the bench scenarios can show the full unlock sequence from software's side: the key value opening slot 2, the scratch value surviving a period of indexed access, a read-modify-write that keeps the outer bits, and the pin returning high only when the shift register finishes.

// File: rtl/uart_idx_pkg.sv
package uart_idx_pkg;

  localparam int REG_W = 8;

  // register slots (byte address >> 2)
  localparam int SLOT_FEAT  = 2;
  localparam int SLOT_LCTL  = 3;
  localparam int SLOT_MCTL  = 4;
  localparam int SLOT_STAT  = 5;
  localparam int SLOT_SCRA  = 7;

  localparam logic [REG_W-1:0] CFG_KEY = 8'hBF;
  localparam int XCTL_BIT  = 4;   // extended-control enable in feature reg
  localparam int DMODE_LO  = 3;   // DTR mode field [4:3]
  localparam logic [REG_W-1:0] AUXC_INDEX = 8'h00;
  localparam logic [1:0] DMODE_TXEN_LOW = 2'b10;

  typedef struct packed {
    logic feat;   // feature register (config view)
    logic lctl;   // line control
    logic mctl;   // modem control
    logic stat;   // line status passthrough
    logic val;    // indexed data window
    logic scra;   // plain scratch
    logic idx;    // index pointer
  } slot_sel_t;

  // pin level for the DTR output
  function automatic logic dtr_level(input logic [1:0] mode,
                                     input logic       mctl_dtr,
                                     input logic       tx_busy);
    if (mode == DMODE_TXEN_LOW) return ~tx_busy;
    return ~mctl_dtr;
  endfunction

  // transmitter occupancy: queue holds data or a character is still going out
  function automatic logic tx_occupied(input logic q_empty,
                                       input logic shift_busy);
    return (~q_empty) | shift_busy;
  endfunction

endpackage

// File: rtl/uart_idx_decode.sv
module uart_idx_decode
  import uart_idx_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int REG_SHIFT = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              cfg_view,
  input  logic              xctl_en,
  output slot_sel_t         sel
);
  localparam int SLOT_W = ADDR_W - REG_SHIFT;

  logic [SLOT_W-1:0] slot;
  logic              unused_addr_lo;

  assign slot           = addr[ADDR_W-1:REG_SHIFT];
  assign unused_addr_lo = ^addr[REG_SHIFT-1:0];

  always_comb begin
    sel      = '0;
    sel.feat = cfg_view && (slot == SLOT_W'(SLOT_FEAT));
    sel.lctl = (slot == SLOT_W'(SLOT_LCTL));
    sel.mctl = !cfg_view && (slot == SLOT_W'(SLOT_MCTL));
    sel.stat = !cfg_view && !xctl_en && (slot == SLOT_W'(SLOT_STAT));
    sel.val  = !cfg_view &&  xctl_en && (slot == SLOT_W'(SLOT_STAT));
    sel.scra = !cfg_view && !xctl_en && (slot == SLOT_W'(SLOT_SCRA));
    sel.idx  = !cfg_view &&  xctl_en && (slot == SLOT_W'(SLOT_SCRA));
  end

endmodule

// File: rtl/uart_idx_regs.sv
module uart_idx_regs
  import uart_idx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             rd,
  input  logic [REG_W-1:0] wdata,
  input  slot_sel_t        sel,
  input  logic [REG_W-1:0] line_status,
  output logic [REG_W-1:0] rdata,
  output logic             cfg_view,
  output logic             xctl_en,
  output logic             mctl_dtr,
  output logic [1:0]       dtr_mode
);
  logic [REG_W-1:0] lctl_q, mctl_q, scra_q, feat_q, idx_q, auxc_q;
  logic [REG_W-1:0] rd_val;

  // named write events
  logic wr_feat, wr_lctl, wr_mctl, wr_scra, wr_idx, wr_val, wr_auxc;
  logic idx_hits_auxc;

  assign idx_hits_auxc = (idx_q == AUXC_INDEX);
  assign wr_feat = wr && sel.feat;
  assign wr_lctl = wr && sel.lctl;
  assign wr_mctl = wr && sel.mctl;
  assign wr_scra = wr && sel.scra;
  assign wr_idx  = wr && sel.idx;
  assign wr_val  = wr && sel.val;
  assign wr_auxc = wr_val && idx_hits_auxc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lctl_q <= '0;
      mctl_q <= '0;
      scra_q <= '0;
      feat_q <= '0;
      idx_q  <= '0;
      auxc_q <= '0;
    end else begin
      if (wr_lctl) lctl_q <= wdata;
      if (wr_mctl) mctl_q <= wdata;
      if (wr_scra) scra_q <= wdata;
      if (wr_feat) feat_q <= wdata;
      if (wr_idx)  idx_q  <= wdata;
      if (wr_auxc) auxc_q <= wdata;
    end
  end

  always_comb begin
    rd_val = '0;
    if (sel.feat) rd_val = feat_q;
    if (sel.lctl) rd_val = lctl_q;
    if (sel.mctl) rd_val = mctl_q;
    if (sel.stat) rd_val = line_status;
    if (sel.scra) rd_val = scra_q;
    if (sel.idx)  rd_val = idx_q;
    if (sel.val)  rd_val = idx_hits_auxc ? auxc_q : '0;
  end

  assign rdata    = rd ? rd_val : '0;
  assign cfg_view = (lctl_q == CFG_KEY);
  assign xctl_en  = feat_q[XCTL_BIT];
  assign mctl_dtr = mctl_q[0];
  assign dtr_mode = auxc_q[DMODE_LO +: 2];

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel)); // R2
  AST_FEAT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && sel.feat) |=> $stable(feat_q)); // R3
  AST_SCRA_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && sel.scra) |=> $stable(scra_q)); // R5
  AST_AUXC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && sel.val) |=> $stable(auxc_q)); // R6
  AST_AUXC_OTHER_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel.val && (idx_q != AUXC_INDEX)) |=> $stable(auxc_q)); // R7
  AST_READ_NO_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(lctl_q) && $stable(mctl_q) && $stable(idx_q) &&
             $stable(feat_q))); // R10

endmodule

// File: rtl/uart_dtr_drive.sv
module uart_dtr_drive
  import uart_idx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] dtr_mode,
  input  logic       mctl_dtr,
  input  logic       txq_empty,
  input  logic       shift_busy,
  output logic       dtr_pin
);
  logic tx_busy;
  logic txen_mode;
  logic dtr_q;

  assign tx_busy   = tx_occupied(txq_empty, shift_busy);
  assign txen_mode = (dtr_mode == DMODE_TXEN_LOW);

  always_ff @(posedge clk) begin
    if (!rst_n) dtr_q <= 1'b1;
    else        dtr_q <= dtr_level(dtr_mode, mctl_dtr, tx_busy);
  end

  assign dtr_pin = dtr_q;

  AST_DTR_TXEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (txen_mode && (!txq_empty || shift_busy)) |=> !dtr_pin); // R9
  AST_DTR_TXEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (txen_mode && txq_empty && !shift_busy) |=> dtr_pin); // R9
  AST_DTR_COMPAT: assert property (@(posedge clk) disable iff (!rst_n)
    !txen_mode |=> (dtr_pin == !$past(mctl_dtr))); // R8

endmodule

// File: rtl/uart_idx_ext.sv
module uart_idx_ext
  import uart_idx_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int REG_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        line_status_i,
  input  logic              txq_empty_i,
  input  logic              tx_shift_busy_i,
  output logic              dtr_pin_o
);
  slot_sel_t  sel;
  logic       cfg_view;
  logic       xctl_en;
  logic       mctl_dtr;
  logic [1:0] dtr_mode;

  uart_idx_decode #(.ADDR_W(ADDR_W), .REG_SHIFT(REG_SHIFT)) u_decode (
    .addr     (bus_addr),
    .cfg_view (cfg_view),
    .xctl_en  (xctl_en),
    .sel      (sel)
  );

  uart_idx_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (bus_wr),
    .rd          (bus_rd),
    .wdata       (bus_wdata),
    .sel         (sel),
    .line_status (line_status_i),
    .rdata       (bus_rdata),
    .cfg_view    (cfg_view),
    .xctl_en     (xctl_en),
    .mctl_dtr    (mctl_dtr),
    .dtr_mode    (dtr_mode)
  );

  uart_dtr_drive u_dtr (
    .clk        (clk),
    .rst_n      (rst_n),
    .dtr_mode   (dtr_mode),
    .mctl_dtr   (mctl_dtr),
    .txq_empty  (txq_empty_i),
    .shift_busy (tx_shift_busy_i),
    .dtr_pin    (dtr_pin_o)
  );

endmodule

// File: tb/uart_idx_ext_tb.sv
module uart_idx_ext_tb;
  localparam int AW = 5;
  localparam logic [AW-1:0] A_S0 = 5'd0, A_S1 = 5'd4, A_FEAT = 5'd8,
    A_LCTL = 5'd12, A_MCTL = 5'd16, A_STAT = 5'd20, A_S6 = 5'd24, A_SCRA = 5'd28;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] line_status_i = 8'h60;
  logic txq_empty_i = 1, tx_shift_busy_i = 0;
  logic dtr_pin_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_idx_ext #(.ADDR_W(AW)) u_dut (.*);

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata;
    bus_rd = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic set_xctl(input bit on);
    wr(A_LCTL, 8'hBF);
    wr(A_FEAT, on ? 8'h10 : 8'h00);
    wr(A_LCTL, 8'h03);
  endtask

  task automatic dtr_chk(input string tag, input logic exp);
    @(negedge clk); @(negedge clk);
    check(tag, {7'd0, dtr_pin_o}, {7'd0, exp});
  endtask

  task automatic t_reset;
    rd_chk("R1 lctl", A_LCTL, 8'h00);
    rd_chk("R1 mctl", A_MCTL, 8'h00);
    rd_chk("R1 scratch", A_SCRA, 8'h00);
    wr(A_LCTL, 8'hBF);
    rd_chk("R1 feature", A_FEAT, 8'h00);
    wr(A_LCTL, 8'h00);
    check("R1 dtr", {7'd0, dtr_pin_o}, 8'h01);
  endtask

  task automatic t_decode;
    wr(A_SCRA | 5'd3, 8'h5A);
    rd_chk("R2 low bits ignored", A_SCRA | 5'd1, 8'h5A);
    wr(A_S0, 8'hFF); wr(A_S1, 8'hFF); wr(A_S6, 8'hFF);
    rd_chk("R2 slot0", A_S0, 8'h00);
    rd_chk("R2 slot1", A_S1, 8'h00);
    rd_chk("R2 slot6", A_S6, 8'h00);
    rd_chk("R2 scratch untouched", A_SCRA, 8'h5A);
  endtask

  task automatic t_feat_gate;
    wr(A_FEAT, 8'h10);
    rd_chk("R3 slot2 normal view", A_FEAT, 8'h00);
    wr(A_LCTL, 8'hBF);
    rd_chk("R3 feature not written outside cfg", A_FEAT, 8'h00);
    wr(A_FEAT, 8'h2C);
    rd_chk("R3 feature rw", A_FEAT, 8'h2C);
    rd_chk("R3 lctl in cfg", A_LCTL, 8'hBF);
    rd_chk("R3 slot7 hidden", A_SCRA, 8'h00);
    wr(A_MCTL, 8'h01);
    wr(A_SCRA, 8'hEE);
    wr(A_FEAT, 8'h00);
    wr(A_LCTL, 8'h03);
    rd_chk("R3 mctl write ignored in cfg", A_MCTL, 8'h00);
    rd_chk("R3 scratch write ignored in cfg", A_SCRA, 8'h5A);
  endtask

  task automatic t_plain;
    wr(A_SCRA, 8'hA5);
    rd_chk("R4 scratch rw", A_SCRA, 8'hA5);
    line_status_i = 8'h61;
    rd_chk("R4 status passthrough", A_STAT, 8'h61);
    wr(A_STAT, 8'h00);
    line_status_i = 8'h20;
    rd_chk("R4 status after write", A_STAT, 8'h20);
  endtask

  task automatic t_indexed;
    logic [7:0] v;
    set_xctl(1);
    wr(A_SCRA, 8'h00);
    rd_chk("R5 index reg", A_SCRA, 8'h00);
    wr(A_STAT, 8'hE7);
    rd_chk("R6 auxc rw", A_STAT, 8'hE7);
    rd(A_STAT, v);
    v = (v & 8'hE7) | 8'h10;
    wr(A_STAT, v);
    rd_chk("R6 rmw keeps outer bits", A_STAT, 8'hF7);
    wr(A_SCRA, 8'h03);
    rd_chk("R5 index readback", A_SCRA, 8'h03);
    rd_chk("R7 other index reads 0", A_STAT, 8'h00);
    wr(A_STAT, 8'h00);
    wr(A_SCRA, 8'h00);
    rd_chk("R7 auxc unchanged", A_STAT, 8'hF7);
    wr(A_STAT, 8'h00);
    set_xctl(0);
    rd_chk("R5 scratch restored", A_SCRA, 8'hA5);
    rd_chk("R4 status after disable", A_STAT, 8'h20);
  endtask

  task automatic t_dtr_compat;
    wr(A_MCTL, 8'h01);
    dtr_chk("R8 mctl dtr set", 1'b0);
    txq_empty_i = 0; tx_shift_busy_i = 1;
    dtr_chk("R8 tx ignored", 1'b0);
    wr(A_MCTL, 8'h00);
    dtr_chk("R8 mctl dtr clear", 1'b1);
    set_xctl(1); wr(A_SCRA, 8'h00); wr(A_STAT, 8'h08); set_xctl(0);
    dtr_chk("R8 mode 01 compat", 1'b1);
    txq_empty_i = 1; tx_shift_busy_i = 0;
  endtask

  task automatic t_dtr_txen;
    set_xctl(1); wr(A_SCRA, 8'h00); wr(A_STAT, 8'h10); set_xctl(0);
    wr(A_MCTL, 8'h01);
    dtr_chk("R9 idle high, mctl ignored", 1'b1);
    txq_empty_i = 0;
    dtr_chk("R9 queue data low", 1'b0);
    tx_shift_busy_i = 1; txq_empty_i = 1;
    dtr_chk("R9 stop bits low", 1'b0);
    tx_shift_busy_i = 0;
    dtr_chk("R9 release high", 1'b1);
  endtask

  task automatic t_read_quiet;
    @(negedge clk); bus_addr = A_SCRA; bus_rd = 0;
    #1 check("R10 rdata idle", bus_rdata, 8'h00);
    rd_chk("R10 repeated read", A_SCRA, 8'hA5);
    rd_chk("R10 repeated read 2", A_SCRA, 8'hA5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_decode();
    t_feat_gate();
    t_plain();
    t_indexed();
    t_dtr_compat();
    t_dtr_txen();
    t_read_quiet();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule